// File: doc/BRIEF.md
# 16-bit ALU with Borrow-Style Carry Flag

This block is the arithmetic and logic unit of a small register machine. Each cycle it takes a destination operand, a source operand (which may be a register value or an immediate), a 4-bit operation code and the current carry. From these it produces a 16-bit result and a candidate next carry, both combinational. A one-bit flag register keeps the carry from one instruction to the next. That register loads the candidate only when the instruction asserts its flag-write enable.

The add and subtract families are the only operations that produce a new carry. On subtraction the carry acts as a borrow: it is set when the subtrahend plus any incoming borrow is larger than the minuend. The remaining operations pass the stored carry through unchanged:

- move
- bitwise NOT
- two's-complement negate
- byte swap
- nibble swap within each byte

The unary operations act on the source operand.

The flag register has two named states. CARRY_CLR holds carry 0 and CARRY_SET holds carry 1. The transition LOAD happens on a rising edge with the write enable high and sets the state to the candidate carry. The transition HOLD happens with the enable low and keeps the state. The transition RESET happens with synchronous reset high and always goes to CARRY_CLR.

Top module: `alu16_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets carry_q to 0, whatever flag_we and the operation are.
- R2: Move (op_sel 0) gives result = src_val, and carry_nxt equals carry_q.
- R3: Add (op_sel 1) gives result = (dst_val + src_val) mod 2^16, and carry_nxt is the 17th sum bit. For example, 0xFFFF + 0xFFFF gives 0xFFFE with carry 1.
- R4: Add with carry (op_sel 2) also adds carry_q. For example, 3 + 4 with carry 1 gives 8 with carry 0.
- R5: Subtract (op_sel 3) gives result = (dst_val - src_val) mod 2^16, and carry_nxt is 1 exactly when a borrow occurs. For example, 3 - 4 gives 0xFFFF with carry 1, and 4 - 3 gives 1 with carry 0.
- R6: Subtract with carry (op_sel 4) also subtracts carry_q as a borrow. For example, 5 - 3 - 1 gives 1 with carry 0.
- R7: NOT (op_sel 5) gives result = bitwise inverse of src_val.
- R8: Negate (op_sel 6) gives result = (0 - src_val) mod 2^16. For example, 1 becomes 0xFFFF.
- R9: Byte swap (op_sel 7) exchanges the low byte and the high byte of src_val. For example, 0x1234 becomes 0x3412.
- R10: Nibble swap (op_sel 8) exchanges the two nibbles inside each byte of src_val. For example, 0x1234 becomes 0x2143.
- R11: carry_q takes the value of carry_nxt at a rising edge when flag_we is high, and keeps its value when flag_we is low.
- R12: NOT, negate, byte swap and nibble swap give carry_nxt = carry_q, so writing the flag after them leaves carry_q unchanged.
- R13: Unused codes (op_sel 9 to 15) give result = dst_val and carry_nxt = carry_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Operation code |
| dst_val | input | 16 | Destination (first) operand |
| src_val | input | 16 | Source operand, register or immediate |
| flag_we | input | 1 | Flag-write enable for this instruction |
| result | output | 16 | Combinational result |
| carry_nxt | output | 1 | Candidate carry for this instruction |
| carry_q | output | 1 | Stored carry flag |

## Verification
The bench targets the 16-bit wrap points: 0xFFFF + 0xFFFF, carry-in that pushes a sum across the wrap, and subtractions where the incoming borrow alone causes underflow. A design with the borrow sense inverted, or one that forgot to chain the incoming carry, would report the wrong carry or be off by one. Swaps use asymmetric values such as 0x1234, so that swapping the wrong nibble pair or leaving a byte in place shows up in the result. The bench also writes the flag after carry-neutral operations and with the enable low. A design that loaded a stale or zero carry there would lose the flag held over from the previous instruction.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SUB  = 4'd3,
        OP_SBC  = 4'd4,
        OP_NOT  = 4'd5,
        OP_NEG  = 4'd6,
        OP_BSWP = 4'd7,
        OP_NSWP = 4'd8
    } alu_op_e;

    typedef enum logic {
        CARRY_CLR = 1'b0,
        CARRY_SET = 1'b1
    } carry_st_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    sum,
    output logic            cout,
    output logic            hit
);
    localparam int EW = W + 1;

    logic [EW-1:0] ext;
    logic [EW-1:0] ea;
    logic [EW-1:0] eb;
    logic [EW-1:0] ec;

    assign ea = {1'b0, a};
    assign eb = {1'b0, b};
    assign ec = {{W{1'b0}}, cin};

    always_comb begin
        ext = '0;
        hit = 1'b1;
        unique case (alu_op_e'(op))
            OP_ADD:  ext = ea + eb;
            OP_ADC:  ext = ea + eb + ec;
            OP_SUB:  ext = ea - eb;
            OP_SBC:  ext = ea - eb - ec;
            default: hit = 1'b0;
        endcase
    end

    // bit W is the carry for additions and the borrow for subtractions
    assign sum  = ext[W-1:0];
    assign cout = ext[W];
endmodule

// File: rtl/alu16_shuffle.sv
module alu16_shuffle
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res,
    output logic            hit
);
    localparam int NBYTE = W / 8;
    localparam int NPAIR = NBYTE / 2;

    logic [W-1:0] bswp;
    logic [W-1:0] nswp;

    // byte swap: exchange the bytes of every 16-bit pair
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign bswp[16*p +: 8]     = b[16*p + 8 +: 8];
        assign bswp[16*p + 8 +: 8] = b[16*p +: 8];
    end
    if (W > 16 * NPAIR) begin : g_tail
        assign bswp[W-1:16*NPAIR] = b[W-1:16*NPAIR];
    end

    // nibble swap inside each byte
    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        assign nswp[8*k +: 4]     = b[8*k + 4 +: 4];
        assign nswp[8*k + 4 +: 4] = b[8*k +: 4];
    end

    always_comb begin
        res = '0;
        hit = 1'b1;
        unique case (alu_op_e'(op))
            OP_MOV:  res = b;
            OP_NOT:  res = ~b;
            OP_NEG:  res = '0 - b;
            OP_BSWP: res = bswp;
            OP_NSWP: res = nswp;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu16_flag.sv
module alu16_flag
    import alu16_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic d,
    output logic q
);
    carry_st_e st_q;
    carry_st_e st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= CARRY_CLR;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (we) st_d = d ? CARRY_SET : CARRY_CLR;
    end

    assign q = (st_q == CARRY_SET);
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] dst_val,
    input  logic [WIDTH-1:0] src_val,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic             carry_nxt,
    output logic             carry_q
);
    logic [WIDTH-1:0] ar_sum;
    logic             ar_cout;
    logic             ar_hit;
    logic [WIDTH-1:0] sh_res;
    logic             sh_hit;

    alu16_arith #(.W(WIDTH)) i_arith (
        .op   (op_sel),
        .a    (dst_val),
        .b    (src_val),
        .cin  (carry_q),
        .sum  (ar_sum),
        .cout (ar_cout),
        .hit  (ar_hit)
    );

    alu16_shuffle #(.W(WIDTH)) i_shuffle (
        .op  (op_sel),
        .b   (src_val),
        .res (sh_res),
        .hit (sh_hit)
    );

    always_comb begin
        if (ar_hit) begin
            result    = ar_sum;
            carry_nxt = ar_cout;
        end else if (sh_hit) begin
            result    = sh_res;
            carry_nxt = carry_q;
        end else begin
            result    = dst_val;
            carry_nxt = carry_q;
        end
    end

    alu16_flag i_flag (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (carry_nxt),
        .q   (carry_q)
    );
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] op_sel,
    input logic [W-1:0]    dst_val,
    input logic [W-1:0]    src_val,
    input logic            flag_we,
    input logic [W-1:0]    result,
    input logic            carry_nxt,
    input logic            carry_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> !carry_q);

    // R11
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> carry_q == $past(carry_nxt));

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(carry_q));

    // R2
    move_copy_chk: assert property (@(posedge clk) disable iff (rst)
        op_sel == OP_MOV |-> result == src_val && carry_nxt == carry_q);

    // R7
    not_invert_chk: assert property (@(posedge clk) disable iff (rst)
        op_sel == OP_NOT |-> (result ^ src_val) == {W{1'b1}});

    // R8
    neg_sum_zero_chk: assert property (@(posedge clk) disable iff (rst)
        op_sel == OP_NEG |-> W'(result + src_val) == '0);

    // R12
    neutral_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= OP_NOT && op_sel <= OP_NSWP) |-> carry_nxt == carry_q);

    // R13
    unused_pass_chk: assert property (@(posedge clk) disable iff (rst)
        op_sel > OP_NSWP |-> result == dst_val && carry_nxt == carry_q);

    // R9
    bswap_chk: assert property (@(posedge clk) disable iff (rst)
        op_sel == OP_BSWP |-> result[7:0] == src_val[15:8] && result[15:8] == src_val[7:0]);
endmodule

bind alu16_core alu16_core_chk #(.W(WIDTH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .op_sel    (op_sel),
    .dst_val   (dst_val),
    .src_val   (src_val),
    .flag_we   (flag_we),
    .result    (result),
    .carry_nxt (carry_nxt),
    .carry_q   (carry_q)
);

// File: tb/test_alu16_core.sv
`timescale 1ns/1ps
module test_alu16_core;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_sel;
    logic [15:0] dst_val;
    logic [15:0] src_val;
    logic        flag_we;
    logic [15:0] result;
    logic        carry_nxt;
    logic        carry_q;

    int total = 0;
    int bad   = 0;
    int m_carry = 0;

    always #2 clk = ~clk;

    alu16_core i_alu16_core (
        .clk(clk), .rst(rst), .op_sel(op_sel), .dst_val(dst_val),
        .src_val(src_val), .flag_we(flag_we), .result(result),
        .carry_nxt(carry_nxt), .carry_q(carry_q)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2";  1: return "R3";  2: return "R4";
            3: return "R5";  4: return "R6";  5: return "R7";
            6: return "R8";  7: return "R9";  8: return "R10";
            default: return "R13";
        endcase
    endfunction

    // behavioural reference: returns {carry, result}
    function automatic int model(input int op, input int d, input int s, input int c);
        int t;
        int r;
        int co;
        co = c;
        case (op)
            0: r = s;
            1: begin t = d + s;     r = t & 16'hFFFF; co = (t > 65535) ? 1 : 0; end
            2: begin t = d + s + c; r = t & 16'hFFFF; co = (t > 65535) ? 1 : 0; end
            3: begin t = d - s;     r = t & 16'hFFFF; co = (t < 0) ? 1 : 0; end
            4: begin t = d - s - c; r = t & 16'hFFFF; co = (t < 0) ? 1 : 0; end
            5: r = 65535 - s;
            6: r = (65536 - s) & 16'hFFFF;
            7: r = ((s & 8'hFF) << 8) | (s >> 8);
            8: r = ((s & 16'h0F0F) << 4) | ((s >> 4) & 16'h0F0F);
            default: r = d;
        endcase
        return (co << 16) | r;
    endfunction

    // drive at negedge, check combinational outputs mid-cycle, then the flag after the edge
    task automatic run_op(input int op, input int d, input int s, input bit we);
        int exp;
        @(negedge clk);
        op_sel = 4'(op); dst_val = 16'(d); src_val = 16'(s); flag_we = we;
        #1;
        exp = model(op, d, s, m_carry);
        check({tag_of(op), " result"}, int'(result), exp & 16'hFFFF);
        check(op >= 5 && op <= 8 ? "R12 carry_nxt" : {tag_of(op), " carry_nxt"},
              int'(carry_nxt), exp >> 16);
        @(posedge clk);
        if (we) m_carry = exp >> 16;
        #1;
        check(we ? "R11 load" : "R11 hold", int'(carry_q), m_carry);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; op_sel = 4'd1; dst_val = 16'hFFFF; src_val = 16'hFFFF; flag_we = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset with carry-producing op", int'(carry_q), 0);
        @(negedge clk);
        rst = 1'b0;

        // move keeps carry; set carry via add overflow first
        run_op(1, 16'hFFFF, 16'hFFFF, 1);   // R3 0xFFFE carry 1
        run_op(0, 4, 3, 1);                 // R2 carry stays 1
        run_op(1, 3, 4, 1);                 // R3 7 carry 0
        run_op(2, 3, 4, 1);                 // R4 carry 0 -> 7
        run_op(1, 16'hFFFF, 1, 1);          // set carry
        run_op(2, 3, 4, 1);                 // R4 3+4+1=8 carry 0
        run_op(1, 16'hFFFF, 16'hFFFF, 1);
        run_op(2, 16'hFFFF, 0, 1);          // R4 carry-in wraps
        run_op(3, 3, 4, 1);                 // R5 0xFFFF borrow 1
        run_op(4, 5, 3, 1);                 // R6 5-3-1=1 carry 0
        run_op(3, 4, 3, 1);                 // R5 1 carry 0
        run_op(3, 0, 1, 1);                 // borrow set
        run_op(4, 0, 0, 1);                 // R6 borrow alone underflows
        run_op(5, 0, 0, 1);                 // R7 / R12 carry stays 1
        run_op(6, 0, 1, 1);                 // R8
        run_op(7, 0, 16'h1234, 1);          // R9
        run_op(8, 0, 16'h1234, 1);          // R10
        run_op(9, 16'hBEEF, 1, 1);          // R13
        run_op(15, 16'h0042, 7, 1);         // R13
        run_op(1, 1, 1, 1);                 // clear carry
        run_op(3, 0, 1, 0);                 // R11 hold: borrow not stored
        run_op(5, 16'h00FF, 16'h0F0F, 1);

        for (int i = 0; i < 400; i++)
            run_op(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)),
                   int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)));

        // reset in the middle clears a set carry (R1)
        run_op(1, 16'hFFFF, 16'hFFFF, 1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_carry = 0;
        check("R1 mid-run reset", int'(carry_q), 0);
        @(negedge clk);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule